// File: doc/BRIEF.md
# Block Address Translation Unit

This block maps a 32-bit effective address to a physical address in a single combinational step, using a small table of large, variable-sized address blocks. It holds two independent sets of entries, one for instruction fetches and one for data accesses. Each entry is a pair of 32-bit words: an upper (match) word and a lower (target) word. The access type selects the set. The privilege level decides which entries in that set may match. The first valid entry in index order supplies the physical address and the access permission.

When translation is disabled for an access, the address passes through unchanged with full read and write permission. When no entry matches, the block reports a miss, and on the next clock edge it captures the effective address in a fault-address register. Entries are loaded one word at a time through a plain register write port.

The request side carries no back-pressure. The block is always ready, a request is taken in every cycle that `req_valid` is high, and the response is valid in that same cycle. `req_valid` only qualifies the protection-fault output and the fault-address capture.

Top module: `blk_xlate_unit`

## Requirements
- R1: After reset every entry word is zero, so no entry is valid and every translated access misses, and `fault_addr` reads zero.
- R2: When `xlat_data_en` is 0, or when the access is a fetch and `xlat_fetch_en` is 0, the response is hit=1, pa equal to the effective address, read and write both granted, and no protection fault.
- R3: A fetch (`req_fetch`=1) uses only the instruction set, and any other access uses only the data set.
- R4: An entry matches only if effective-address bits [31:28] equal upper-word bits [31:28].
- R5: Upper-word bits [12:2] form an 11-bit block-length mask over effective-address bits [27:17]. Effective-address bits [27:17] with the masked bits cleared must equal upper-word bits [27:17].
- R6: Upper-word bit 1 validates the entry for supervisor accesses (`req_user`=0), and upper-word bit 0 validates it for user accesses. An entry that is not valid for the current mode is skipped and does not block later entries.
- R7: When several entries match, the lowest index wins.
- R8: On a hit the physical address is lower[31:28], then (EA[27:17] AND mask) OR lower[27:17], then EA[16:0].
- R9: Lower-word bits [1:0] set the permission: 00 grants nothing, 01 grants read only, 10 and 11 grant read and write.
- R10: A valid request that hits but lacks the needed right (write for `req_write`=1, read otherwise) raises `rsp_prot_fault`, and `rsp_hit` stays 1.
- R11: A valid translated request with no matching entry gives hit=0, no permission and no protection fault, and loads its effective address into `fault_addr` at the next clock edge. In all other cycles `fault_addr` holds its value.
- R12: With `cfg_we`=1, `cfg_wdata` is written to the word chosen by `cfg_fetch_set` (1 = instruction set), `cfg_idx` and `cfg_lower` (1 = lower word). Translation uses the new value from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Entry word write strobe |
| cfg_fetch_set | input | 1 | Write target set: 1 instruction, 0 data |
| cfg_idx | input | 2 | Entry index to write |
| cfg_lower | input | 1 | Word select: 1 lower, 0 upper |
| cfg_wdata | input | 32 | Word to write |
| xlat_fetch_en | input | 1 | Instruction translation enable |
| xlat_data_en | input | 1 | Data translation enable |
| req_valid | input | 1 | Request present this cycle |
| req_fetch | input | 1 | Access is an instruction fetch |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is in user mode |
| req_ea | input | 32 | Effective address |
| rsp_hit | output | 1 | Translation hit or pass-through |
| rsp_pa | output | 32 | Physical address |
| rsp_rd_ok | output | 1 | Read permitted |
| rsp_wr_ok | output | 1 | Write permitted |
| rsp_prot_fault | output | 1 | Hit without the required right |
| fault_addr | output | 32 | Last missing effective address |

## Verification
Two things can happen in the same cycle: a miss that loads `fault_addr`, and an entry write that changes whether the following request hits. The bench places an entry write directly after a missing request and then repeats an access against the new entry, to show that the write takes effect on the next cycle and does not disturb the captured fault address. Priority and masking can also resolve in the same lookup, where a lower entry is skipped because of privilege and a higher one matches through its mask. Sweeps over tag, mask-sensitive middle bits, privilege, access type and both enables compare every output with an arithmetic model built from the words the bench has written.

// File: rtl/blk_xlate_pkg.sv
package blk_xlate_pkg;

  localparam int ADDR_W  = 32;
  localparam int TAG_HI  = 31;
  localparam int TAG_LO  = 28;
  localparam int MID_HI  = 27;
  localparam int MID_LO  = 17;
  localparam int MID_W   = MID_HI - MID_LO + 1;
  localparam int LEN_HI  = 12;
  localparam int LEN_LO  = 2;
  localparam int SUP_BIT = 1;
  localparam int USR_BIT = 0;

  typedef struct packed {
    logic [ADDR_W-1:0] upper;
    logic [ADDR_W-1:0] lower;
  } xl_entry_t;

  typedef struct packed {
    logic [ADDR_W-1:0] pa;
    logic              rd;
    logic              wr;
  } xl_res_t;

endpackage

// File: rtl/blk_xlate_bank.sv
module blk_xlate_bank
  import blk_xlate_pkg::*;
#(
  parameter int N_ENTRY = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [$clog2(N_ENTRY)-1:0] wr_idx,
  input  logic                       wr_lower,
  input  logic [ADDR_W-1:0]          wr_data,
  output xl_entry_t [N_ENTRY-1:0]    ents_o
);

  for (genvar i = 0; i < N_ENTRY; i++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ents_o[i] <= '0;
      end else if (wr_en && (wr_idx == i[$clog2(N_ENTRY)-1:0])) begin
        if (wr_lower) ents_o[i].lower <= wr_data;
        else          ents_o[i].upper <= wr_data;
      end
    end
  end

endmodule

// File: rtl/blk_xlate_cmp.sv
module blk_xlate_cmp
  import blk_xlate_pkg::*;
(
  input  xl_entry_t          ent_i,
  input  logic [ADDR_W-1:0]  ea_i,
  input  logic               user_i,
  output logic               match_o,
  output xl_res_t            res_o
);

  logic [MID_W-1:0] len_mask;
  logic             tag_ok;
  logic             mid_ok;
  logic             priv_ok;
  logic             unused_bits;

  assign len_mask = ent_i.upper[LEN_HI:LEN_LO];
  assign tag_ok   = ea_i[TAG_HI:TAG_LO] == ent_i.upper[TAG_HI:TAG_LO];
  assign mid_ok   = (ea_i[MID_HI:MID_LO] & ~len_mask) == ent_i.upper[MID_HI:MID_LO];
  assign priv_ok  = user_i ? ent_i.upper[USR_BIT] : ent_i.upper[SUP_BIT];
  assign match_o  = tag_ok && mid_ok && priv_ok;

  assign res_o.pa = {ent_i.lower[TAG_HI:TAG_LO],
                     (ea_i[MID_HI:MID_LO] & len_mask) | ent_i.lower[MID_HI:MID_LO],
                     ea_i[MID_LO-1:0]};
  assign res_o.rd = ent_i.lower[1] | ent_i.lower[0];
  assign res_o.wr = ent_i.lower[1];

  assign unused_bits = ^{ent_i.upper[MID_LO-1:LEN_HI+1], ent_i.lower[MID_LO-1:2]};

endmodule

// File: rtl/blk_xlate_pick.sv
module blk_xlate_pick
  import blk_xlate_pkg::*;
#(
  parameter int N_ENTRY = 4
) (
  input  logic [N_ENTRY-1:0]     match_i,
  input  xl_res_t [N_ENTRY-1:0]  res_i,
  output logic                   any_o,
  output xl_res_t                res_o
);

  always_comb begin
    any_o = 1'b0;
    res_o = '0;
    for (int i = N_ENTRY - 1; i >= 0; i--) begin
      if (match_i[i]) begin
        any_o = 1'b1;
        res_o = res_i[i];
      end
    end
  end

endmodule

// File: rtl/blk_xlate_unit.sv
module blk_xlate_unit
  import blk_xlate_pkg::*;
#(
  parameter int N_ENTRY = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_we,
  input  logic                       cfg_fetch_set,
  input  logic [$clog2(N_ENTRY)-1:0] cfg_idx,
  input  logic                       cfg_lower,
  input  logic [31:0]                cfg_wdata,
  input  logic                       xlat_fetch_en,
  input  logic                       xlat_data_en,
  input  logic                       req_valid,
  input  logic                       req_fetch,
  input  logic                       req_write,
  input  logic                       req_user,
  input  logic [31:0]                req_ea,
  output logic                       rsp_hit,
  output logic [31:0]                rsp_pa,
  output logic                       rsp_rd_ok,
  output logic                       rsp_wr_ok,
  output logic                       rsp_prot_fault,
  output logic [31:0]                fault_addr
);

  localparam int N_SET = 2;

  xl_entry_t [N_ENTRY-1:0] set_ents [N_SET];
  xl_entry_t [N_ENTRY-1:0] act_ents;
  logic      [N_ENTRY-1:0] ent_match;
  xl_res_t   [N_ENTRY-1:0] ent_res;
  logic                    blk_hit;
  xl_res_t                 blk_res;
  logic                    pass_thru;
  logic                    miss;

  for (genvar s = 0; s < N_SET; s++) begin : g_set
    blk_xlate_bank #(.N_ENTRY(N_ENTRY)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (cfg_we && (cfg_fetch_set == 1'(s))),
      .wr_idx   (cfg_idx),
      .wr_lower (cfg_lower),
      .wr_data  (cfg_wdata),
      .ents_o   (set_ents[s])
    );
  end

  assign act_ents = req_fetch ? set_ents[1] : set_ents[0];

  for (genvar i = 0; i < N_ENTRY; i++) begin : g_cmp
    blk_xlate_cmp u_cmp (
      .ent_i   (act_ents[i]),
      .ea_i    (req_ea),
      .user_i  (req_user),
      .match_o (ent_match[i]),
      .res_o   (ent_res[i])
    );
  end

  blk_xlate_pick #(.N_ENTRY(N_ENTRY)) u_pick (
    .match_i (ent_match),
    .res_i   (ent_res),
    .any_o   (blk_hit),
    .res_o   (blk_res)
  );

  assign pass_thru = !xlat_data_en || (req_fetch && !xlat_fetch_en);

  always_comb begin
    if (pass_thru) begin
      rsp_hit   = 1'b1;
      rsp_pa    = req_ea;
      rsp_rd_ok = 1'b1;
      rsp_wr_ok = 1'b1;
    end else begin
      rsp_hit   = blk_hit;
      rsp_pa    = blk_res.pa;
      rsp_rd_ok = blk_hit && blk_res.rd;
      rsp_wr_ok = blk_hit && blk_res.wr;
    end
  end

  assign rsp_prot_fault = req_valid && rsp_hit && (req_write ? !rsp_wr_ok : !rsp_rd_ok);
  assign miss           = req_valid && !rsp_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    fault_addr <= '0;
    else if (miss) fault_addr <= req_ea;
  end

endmodule

// File: rtl/blk_xlate_chk.sv
module blk_xlate_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        xlat_fetch_en,
  input logic        xlat_data_en,
  input logic        req_valid,
  input logic        req_fetch,
  input logic        req_ea_dummy,
  input logic [31:0] req_ea,
  input logic        rsp_hit,
  input logic [31:0] rsp_pa,
  input logic        rsp_rd_ok,
  input logic        rsp_wr_ok,
  input logic        rsp_prot_fault,
  input logic [31:0] fault_addr
);

  logic pt_req;
  assign pt_req = !xlat_data_en || (req_fetch && !xlat_fetch_en);

  assert_passthru_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pt_req |-> (rsp_hit && rsp_pa == req_ea && rsp_rd_ok && rsp_wr_ok && !rsp_prot_fault));

  assert_miss_capture_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !rsp_hit) |=> fault_addr == $past(req_ea));

  assert_fault_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !rsp_hit) |=> $stable(fault_addr));

  assert_miss_noperm_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_hit |-> (!rsp_rd_ok && !rsp_wr_ok && !rsp_prot_fault));

  assert_wr_has_rd_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_wr_ok |-> rsp_rd_ok);

  assert_offset_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_pa[16:0] == req_ea[16:0]);

  assert_prot_on_hit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_prot_fault |-> (rsp_hit && req_valid));

endmodule

bind blk_xlate_unit blk_xlate_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .xlat_fetch_en  (xlat_fetch_en),
  .xlat_data_en   (xlat_data_en),
  .req_valid      (req_valid),
  .req_fetch      (req_fetch),
  .req_ea_dummy   (req_ea[0]),
  .req_ea         (req_ea),
  .rsp_hit        (rsp_hit),
  .rsp_pa         (rsp_pa),
  .rsp_rd_ok      (rsp_rd_ok),
  .rsp_wr_ok      (rsp_wr_ok),
  .rsp_prot_fault (rsp_prot_fault),
  .fault_addr     (fault_addr)
);

// File: tb/blk_xlate_unit_tb.sv
`timescale 1ns/1ps
module blk_xlate_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic        cfg_fetch_set = 1'b0;
  logic [1:0]  cfg_idx = '0;
  logic        cfg_lower = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        xlat_fetch_en = 1'b0;
  logic        xlat_data_en = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_fetch = 1'b0;
  logic        req_write = 1'b0;
  logic        req_user = 1'b0;
  logic [31:0] req_ea = '0;
  logic        rsp_hit, rsp_rd_ok, rsp_wr_ok, rsp_prot_fault;
  logic [31:0] rsp_pa, fault_addr;

  int n_checks = 0;
  int n_fails  = 0;
  logic [31:0] fault_exp = '0;
  logic [31:0] shu [2][4];
  logic [31:0] shl [2][4];
  bit done = 0;

  always #2.5 clk = ~clk;

  blk_xlate_unit u_dut (.*);

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_up(input logic [3:0] tag, input logic [10:0] mid,
                                        input logic [10:0] len, input logic vs, input logic vu);
    return (32'(tag) << 28) | (32'(mid) << 17) | (32'(len) << 2) | (32'(vs) << 1) | 32'(vu);
  endfunction

  function automatic logic [31:0] mk_lo(input logic [3:0] tag, input logic [10:0] mid, input logic [1:0] pp);
    return (32'(tag) << 28) | (32'(mid) << 17) | 32'(pp);
  endfunction

  task automatic wr_cfg(input logic set, input int idx, input logic lower, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b0;
    cfg_we = 1'b1; cfg_fetch_set = set; cfg_idx = 2'(idx); cfg_lower = lower; cfg_wdata = d;
    if (lower) shl[set][idx] = d; else shu[set][idx] = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic model(input logic [31:0] ea, input logic f, w, u, ien, den,
                       output logic h, output logic [31:0] pa, output logic rd, wr, pf, pt);
    logic [31:0] up, lo, msk;
    pt = !den || (f && !ien);
    h = 0; pa = 0; rd = 0; wr = 0;
    if (pt) begin
      h = 1; pa = ea; rd = 1; wr = 1;
    end else begin
      for (int i = 0; i < 4; i++) begin
        up = shu[f][i]; lo = shl[f][i];
        msk = (up & 32'h0000_1FFC) << 15;
        if (!h && ((ea ^ up) & 32'hF000_0000) == 0 &&
            (ea & 32'h0FFE_0000 & ~msk) == (up & 32'h0FFE_0000) &&
            ((u && up[0]) || (!u && up[1]))) begin
          h  = 1;
          pa = (lo & 32'hF000_0000) | (ea & msk) | (lo & 32'h0FFE_0000) | (ea & 32'h0001_FFFF);
          rd = (lo & 3) != 0;
          wr = (lo & 2) != 0;
        end
      end
    end
    pf = h && (w ? !wr : !rd);
  endtask

  task automatic run(input string lbl, input logic [31:0] ea, input logic f, w, u, ien, den);
    logic h, rd, wr, pf, pt;
    logic [31:0] pa;
    string tg;
    @(negedge clk);
    chk("R11", "fault_addr", fault_addr, fault_exp);
    req_valid = 1'b1; req_ea = ea; req_fetch = f; req_write = w; req_user = u;
    xlat_fetch_en = ien; xlat_data_en = den;
    #1;
    model(ea, f, w, u, ien, den, h, pa, rd, wr, pf, pt);
    tg = lbl;
    if (tg == "") tg = pt ? "R2" : (!h ? "R11" : (pf ? "R10" : "R8"));
    chk(tg, "hit", 32'(rsp_hit), 32'(h));
    chk(tg, "pa", rsp_pa, h ? pa : rsp_pa);
    chk(tg, "rd_ok", 32'(rsp_rd_ok), 32'(rd));
    chk(tg, "wr_ok", 32'(rsp_wr_ok), 32'(wr));
    chk(tg, "prot_fault", 32'(rsp_prot_fault), 32'(pf));
    if (!h) fault_exp = ea;
  endtask

  function automatic logic [31:0] ea_of(input logic [3:0] tag, input logic [10:0] mid, input logic [16:0] off);
    return (32'(tag) << 28) | (32'(mid) << 17) | 32'(off);
  endfunction

  initial begin
    #400000;
    if (!done) begin
      n_checks++; n_fails++;
      $display("FAIL R1 watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    logic [10:0] mids [8];
    mids = '{11'h000, 11'h003, 11'h007, 11'h008, 11'h055, 11'h054, 11'h400, 11'h7FF};
    for (int s = 0; s < 2; s++) for (int i = 0; i < 4; i++) begin shu[s][i] = 0; shl[s][i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1", "fault_addr reset", fault_addr, 32'h0);
    run("R1", ea_of(4'h1, 11'h003, 17'h00123), 0, 0, 0, 1, 1);
    run("R1", ea_of(4'h0, 11'h000, 17'h00000), 1, 0, 1, 1, 1);

    // load entries (R12 write port)
    wr_cfg(0, 0, 0, mk_up(4'h1, 11'h000, 11'h007, 1, 0));
    wr_cfg(0, 0, 1, mk_lo(4'h8, 11'h100, 2'b10));
    wr_cfg(0, 1, 0, mk_up(4'h1, 11'h000, 11'h7FF, 1, 1));
    wr_cfg(0, 1, 1, mk_lo(4'h9, 11'h000, 2'b01));
    wr_cfg(0, 2, 0, mk_up(4'h2, 11'h055, 11'h000, 0, 1));
    wr_cfg(0, 2, 1, mk_lo(4'hA, 11'h011, 2'b00));
    wr_cfg(0, 3, 0, mk_up(4'h2, 11'h055, 11'h000, 1, 1));
    wr_cfg(0, 3, 1, mk_lo(4'hB, 11'h022, 2'b10));
    wr_cfg(1, 0, 0, mk_up(4'h1, 11'h000, 11'h7FF, 1, 1));
    wr_cfg(1, 0, 1, mk_lo(4'hC, 11'h000, 2'b11));

    // directed
    run("R7", ea_of(4'h1, 11'h003, 17'h0ABCD), 0, 0, 0, 1, 1);  // entry 0 beats 1
    run("R5", ea_of(4'h1, 11'h008, 17'h00010), 0, 0, 0, 1, 1);  // bit outside mask -> entry 1
    run("R4", ea_of(4'h3, 11'h000, 17'h00010), 0, 0, 0, 1, 1);  // tag mismatch -> miss
    run("R6", ea_of(4'h1, 11'h003, 17'h00001), 0, 0, 1, 1, 1);  // user skips entry 0
    run("R6", ea_of(4'h2, 11'h055, 17'h1FFFF), 0, 1, 0, 1, 1);  // supervisor skips entry 2
    run("R9", ea_of(4'h2, 11'h055, 17'h00002), 0, 0, 1, 1, 1);  // pp 00 no read
    run("R9", ea_of(4'h1, 11'h008, 17'h00003), 0, 1, 1, 1, 1);  // pp 01 write refused
    run("R3", ea_of(4'h1, 11'h003, 17'h00004), 1, 0, 0, 1, 1);  // fetch uses instruction set
    run("R3", ea_of(4'h2, 11'h055, 17'h00005), 1, 0, 0, 1, 1);  // fetch misses data entry
    run("R2", ea_of(4'h7, 11'h123, 17'h00006), 1, 1, 1, 0, 1);
    // R12: write right after a miss, then use new entry next cycle
    run("R11", ea_of(4'h5, 11'h001, 17'h00777), 0, 0, 0, 1, 1);
    wr_cfg(0, 1, 1, mk_lo(4'h9, 11'h000, 2'b10));
    run("R12", ea_of(4'h1, 11'h008, 17'h00003), 0, 1, 1, 1, 1);
    wr_cfg(0, 1, 1, mk_lo(4'h9, 11'h000, 2'b01));

    // near-exhaustive sweep
    for (int en = 0; en < 4; en++)
      for (int t = 0; t < 16; t++)
        for (int m = 0; m < 8; m++)
          for (int k = 0; k < 8; k++)
            run("", ea_of(4'(t), mids[m], 17'((t * 8 + m) * 17'h0135 + k)),
                k[0], k[1], k[2], en[0], en[1]);

    @(negedge clk);
    chk("R11", "fault_addr final", fault_addr, fault_exp);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

endmodule